// File: doc/BRIEF.md
# FIFO DMA Request and Stop Controller

This block produces the DMA request line for a byte-wide DMA channel that feeds or empties a data FIFO of up to 16 bytes. While a transfer runs it raises the request from the FIFO fill level and the transfer direction. While no transfer runs it can drain leftover FIFO bytes to a host DMA engine, for example after an abort. In that drain mode an alignment enable selects whether one byte is enough to request, or whether two are needed.

The block also gates a DMA-stop request. A stop is held pending until the condition for the current transfer type allows it. When it takes effect, the request line is dropped and the transfer ends. The block then waits until the interrupted bus transfer counts as finished, and signals completion. The FIFO storage and the transfer counters are outside the block: it sees only their count and flag outputs.

Top module: `dma_fifo_req_ctrl`

## Requirements
- R1: After reset `dreq_o`, `stop_o` and `done_o` are 0 and no transfer is active.
- R2: With no transfer active, `drain_i`=1 and `align16_i`=1, `dreq_o` is 1 in the cycle after the FIFO count is 2 or more, and 0 in the cycle after it is 0 or 1.
- R3: With no transfer active, `drain_i`=1 and `align16_i`=0, `dreq_o` is 1 in the cycle after the FIFO count is non-zero, and 0 in the cycle after it is zero.
- R4: A transfer is started by a pulse on `xfer_start_i`. At that pulse the block samples the type: `dir_send_i`=1 means send and 0 means receive, `mode_sync_i`=1 means synchronous and 0 means asynchronous. During a transfer, `dreq_o` follows one cycle later: a send requests while the count is below 16, a receive requests while the count is non-zero.
- R5: During a send transfer of either mode, `stop_o` is asserted only in a cycle where the FIFO count is 0.
- R6: During a synchronous receive, `stop_o` is asserted only in a cycle where `xfer_zero_i` or `sync_ofs_max_i` is 1.
- R7: During an asynchronous receive, `stop_o` is asserted only in a cycle where the FIFO count is 16 (full) or `xfer_zero_i` is 1.
- R8: A stop request arriving while its condition is false stays pending. `stop_o` pulses for one cycle in the first cycle the condition holds. If the condition already holds, that is the cycle of the request.
- R9: In the cycle after `stop_o`, `dreq_o` is 0, and it stays 0 until a new transfer or drain. The transfer ends, and a later stop request has no effect until a new transfer starts.
- R10: After a stop in a synchronous send, `done_o` pulses in the first following cycle in which `xfer_zero_i` is 1.
- R11: After a stop in a synchronous receive, `done_o` pulses in the first following cycle in which `ack_out_i` is 0.
- R12: After a stop in an asynchronous transfer, `done_o` pulses in the cycle right after `stop_o`.
- R13: A stop request while no transfer is active is ignored. A pending stop is discarded when `xfer_end_i` ends the transfer. In both cases no `stop_o` follows in a later transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_cnt_i | input | 5 | FIFO fill level, 0 to 16 |
| xfer_zero_i | input | 1 | Transfer count has reached zero |
| sync_ofs_max_i | input | 1 | Synchronous offset at its maximum |
| dir_send_i | input | 1 | Transfer direction, 1 = send (sampled at start) |
| mode_sync_i | input | 1 | Transfer mode, 1 = synchronous (sampled at start) |
| ack_out_i | input | 5 | Outstanding ACK count |
| xfer_start_i | input | 1 | Pulse: a DMA transfer begins |
| xfer_end_i | input | 1 | Pulse: the transfer ends normally |
| stop_req_i | input | 1 | Pulse: request to stop the DMA transfer |
| drain_i | input | 1 | Residual drain mode enable |
| align16_i | input | 1 | Two-byte drain threshold enable |
| dreq_o | output | 1 | DMA request |
| stop_o | output | 1 | Stop takes effect this cycle |
| done_o | output | 1 | Interrupted transfer finished this cycle |

## Verification
Drain mode is swept over the counts 0, 1, 2, 3 and 16 with both threshold settings. The counts 1 and 2 are the ones that separate the two-byte threshold from the non-empty rule. Each of the four transfer types gets a stop request first while its condition is false and then while it is true. This separates a pending request from an ignored one, and one type's condition from another's, for example a full FIFO against a count of 15 for asynchronous receive. The completion checks hold the count-zero flag or the ACK count away from its finishing value for some cycles. This shows that synchronous completion waits on the right input while asynchronous completion does not.

// File: rtl/dma_stop_pkg.sv
package dma_stop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WIND = 2'd2
  } dma_state_e;

  typedef struct packed {
    logic send;
    logic sync;
  } xfer_kind_t;
endpackage

// File: rtl/dma_dreq_level.sv
module dma_dreq_level
  import dma_stop_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic             in_xfer_i,
  input  logic             idle_i,
  input  logic             drain_i,
  input  logic             align16_i,
  input  xfer_kind_t       kind_i,
  output logic             req_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] PAIR_CNT = CNT_W'(2);

  logic not_empty, has_pair, not_full;

  assign not_empty = (fifo_cnt_i != '0);
  assign has_pair  = (fifo_cnt_i >= PAIR_CNT);
  assign not_full  = (fifo_cnt_i < FULL_CNT);

  always_comb begin
    req_o = 1'b0;
    if (in_xfer_i)
      req_o = kind_i.send ? not_full : not_empty;
    else if (idle_i && drain_i)
      req_o = align16_i ? has_pair : not_empty;
  end
endmodule

// File: rtl/dma_stop_rules.sv
module dma_stop_rules
  import dma_stop_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int ACK_W = 5
) (
  input  xfer_kind_t       kind_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic             xfer_zero_i,
  input  logic             sync_ofs_max_i,
  input  logic [ACK_W-1:0] ack_out_i,
  output logic             eligible_o,
  output logic             finished_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  always_comb begin
    unique case ({kind_i.send, kind_i.sync})
      2'b11, 2'b10: eligible_o = (fifo_cnt_i == '0);
      2'b01:        eligible_o = xfer_zero_i | sync_ofs_max_i;
      default:      eligible_o = (fifo_cnt_i == FULL_CNT) | xfer_zero_i;
    endcase
  end

  // asynchronous types finish at once; synchronous ones wait on the bus
  always_comb begin
    if (!kind_i.sync)     finished_o = 1'b1;
    else if (kind_i.send) finished_o = xfer_zero_i;
    else                  finished_o = (ack_out_i == '0);
  end
endmodule

// File: rtl/dma_fifo_req_ctrl.sv
module dma_fifo_req_ctrl
  import dma_stop_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int ACK_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic             xfer_zero_i,
  input  logic             sync_ofs_max_i,
  input  logic             dir_send_i,
  input  logic             mode_sync_i,
  input  logic [ACK_W-1:0] ack_out_i,
  input  logic             xfer_start_i,
  input  logic             xfer_end_i,
  input  logic             stop_req_i,
  input  logic             drain_i,
  input  logic             align16_i,
  output logic             dreq_o,
  output logic             stop_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  dma_state_e state_q, state_d;
  xfer_kind_t kind_q;
  logic       pend_q, dreq_q;
  logic       in_xfer, idle, eligible, finished, level_req;

  assign in_xfer = (state_q == ST_XFER);
  assign idle    = (state_q == ST_IDLE);

  dma_dreq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
    .fifo_cnt_i (fifo_cnt_i),
    .in_xfer_i  (in_xfer),
    .idle_i     (idle),
    .drain_i    (drain_i),
    .align16_i  (align16_i),
    .kind_i     (kind_q),
    .req_o      (level_req)
  );

  dma_stop_rules #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ACK_W(ACK_W)) u_rules (
    .kind_i         (kind_q),
    .fifo_cnt_i     (fifo_cnt_i),
    .xfer_zero_i    (xfer_zero_i),
    .sync_ofs_max_i (sync_ofs_max_i),
    .ack_out_i      (ack_out_i),
    .eligible_o     (eligible),
    .finished_o     (finished)
  );

  assign stop_o = in_xfer & (pend_q | stop_req_i) & eligible;
  assign done_o = (state_q == ST_WIND) & finished;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (xfer_start_i) state_d = ST_XFER;
      ST_XFER: if (stop_o) state_d = ST_WIND;
               else if (xfer_end_i) state_d = ST_IDLE;
      ST_WIND: if (finished) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= '0;
      pend_q  <= 1'b0;
      dreq_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (idle && xfer_start_i) kind_q <= '{send: dir_send_i, sync: mode_sync_i};
      if (!in_xfer || stop_o || xfer_end_i) pend_q <= 1'b0;
      else if (stop_req_i)                  pend_q <= 1'b1;
      dreq_q <= level_req & ~stop_o & ~(in_xfer & xfer_end_i);
    end
  end

  assign dreq_o = dreq_q;

  assert_stop_send_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && kind_q.send) |-> (fifo_cnt_i == '0));
  assert_stop_sync_rx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !kind_q.send && kind_q.sync) |-> (xfer_zero_i || sync_ofs_max_i));
  assert_stop_async_rx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !kind_q.send && !kind_q.sync) |-> (fifo_cnt_i == FULL_CNT || xfer_zero_i));
  assert_pend_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_xfer && stop_req_i && !stop_o && !xfer_end_i) |=> pend_q);
  assert_dreq_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !dreq_o);
  assert_no_stop_after_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);
  assert_done_async_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !kind_q.sync) |=> done_o);
  assert_drain_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && drain_i && align16_i && fifo_cnt_i < CNT_W'(2)) |=> !dreq_o);
  assert_idle_no_stop_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> !stop_o);
endmodule

// File: tb/dma_fifo_req_ctrl_tb.sv
`timescale 1ns/1ps
module dma_fifo_req_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] fifo_cnt_i = '0;
  logic       xfer_zero_i = 1'b0, sync_ofs_max_i = 1'b0;
  logic       dir_send_i = 1'b0, mode_sync_i = 1'b0;
  logic [4:0] ack_out_i = '0;
  logic       xfer_start_i = 1'b0, xfer_end_i = 1'b0, stop_req_i = 1'b0;
  logic       drain_i = 1'b0, align16_i = 1'b0;
  logic       dreq_o, stop_o, done_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk_i = ~clk_i;

  dma_fifo_req_ctrl u_dut (
    .clk_i, .rst_ni, .fifo_cnt_i, .xfer_zero_i, .sync_ofs_max_i,
    .dir_send_i, .mode_sync_i, .ack_out_i, .xfer_start_i, .xfer_end_i,
    .stop_req_i, .drain_i, .align16_i, .dreq_o, .stop_o, .done_o
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic start_xfer(input logic send, input logic sync);
    dir_send_i = send; mode_sync_i = sync; xfer_start_i = 1'b1;
    tick();
    xfer_start_i = 1'b0;
  endtask

  task automatic quiet();
    fifo_cnt_i = '0; xfer_zero_i = 0; sync_ofs_max_i = 0; ack_out_i = '0;
    stop_req_i = 0; drain_i = 0; xfer_end_i = 0;
  endtask

  task automatic t_reset();
    settle();
    chk(dreq_o, 0, "R1 dreq at reset");
    chk(stop_o, 0, "R1 stop at reset");
    chk(done_o, 0, "R1 done at reset");
  endtask

  task automatic t_drain();
    logic [4:0] cnts [5] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd16};
    drain_i = 1;
    align16_i = 1;
    foreach (cnts[i]) begin
      fifo_cnt_i = cnts[i]; tick();
      chk(dreq_o, cnts[i] >= 2, $sformatf("R2 drain aligned cnt=%0d", cnts[i]));
    end
    align16_i = 0;
    foreach (cnts[i]) begin
      fifo_cnt_i = cnts[i]; tick();
      chk(dreq_o, cnts[i] != 0, $sformatf("R3 drain byte cnt=%0d", cnts[i]));
    end
    quiet(); tick();
  endtask

  task automatic t_xfer_dreq();
    start_xfer(1, 0);
    fifo_cnt_i = 16; tick(); chk(dreq_o, 0, "R4 send full");
    fifo_cnt_i = 15; tick(); chk(dreq_o, 1, "R4 send room");
    xfer_end_i = 1; tick(); xfer_end_i = 0;
    start_xfer(0, 1);
    fifo_cnt_i = 0; tick(); chk(dreq_o, 0, "R4 recv empty");
    fifo_cnt_i = 3; tick(); chk(dreq_o, 1, "R4 recv data");
    xfer_end_i = 1; tick(); xfer_end_i = 0;
    quiet(); tick();
  endtask

  task automatic t_stop_sync_send();
    start_xfer(1, 1);
    fifo_cnt_i = 3; stop_req_i = 1; settle();
    chk(stop_o, 0, "R5 send stop blocked by data");
    tick(); stop_req_i = 0;
    tick(); settle(); chk(stop_o, 0, "R8 still pending");
    fifo_cnt_i = 0; settle(); chk(stop_o, 1, "R8 pending stop fires when empty");
    tick();
    chk(dreq_o, 0, "R9 dreq dropped");
    settle(); chk(done_o, 0, "R10 waits for count zero");
    tick(); chk(done_o, 0, "R10 still waiting");
    xfer_zero_i = 1; settle(); chk(done_o, 1, "R10 done at count zero");
    tick(); settle(); chk(done_o, 0, "R10 single done pulse");
    stop_req_i = 1; settle(); chk(stop_o, 0, "R9 no stop after end");
    quiet(); tick();
  endtask

  task automatic t_stop_sync_recv();
    start_xfer(0, 1);
    fifo_cnt_i = 16; stop_req_i = 1; settle();
    chk(stop_o, 0, "R6 full fifo does not allow sync recv stop");
    tick(); stop_req_i = 0;
    sync_ofs_max_i = 1; ack_out_i = 3; settle();
    chk(stop_o, 1, "R6 stop at offset max");
    tick(); chk(dreq_o, 0, "R9 dreq low after stop");
    settle(); chk(done_o, 0, "R11 waits for acks");
    ack_out_i = 1; tick(); chk(done_o, 0, "R11 ack pending");
    ack_out_i = 0; settle(); chk(done_o, 1, "R11 done when acks in");
    quiet(); tick();
    start_xfer(0, 1);
    xfer_zero_i = 1; stop_req_i = 1; settle();
    chk(stop_o, 1, "R6 R8 immediate stop at count zero");
    tick(); stop_req_i = 0;
    quiet(); tick();
  endtask

  task automatic t_stop_async();
    start_xfer(0, 0);
    fifo_cnt_i = 15; stop_req_i = 1; settle();
    chk(stop_o, 0, "R7 count 15 not full");
    tick(); stop_req_i = 0;
    fifo_cnt_i = 16; settle(); chk(stop_o, 1, "R7 stop when full");
    tick(); chk(done_o, 1, "R12 async recv done next cycle");
    tick(); chk(dreq_o, 0, "R9 dreq stays low");
    start_xfer(1, 0);
    fifo_cnt_i = 2; stop_req_i = 1; settle();
    chk(stop_o, 0, "R5 async send blocked");
    fifo_cnt_i = 0; settle(); chk(stop_o, 1, "R5 async send stop when empty");
    tick(); stop_req_i = 0;
    chk(done_o, 1, "R12 async send done next cycle");
    quiet(); tick();
  endtask

  task automatic t_ignore();
    stop_req_i = 1; tick(); stop_req_i = 0;
    start_xfer(1, 0);
    fifo_cnt_i = 0; settle();
    chk(stop_o, 0, "R13 idle request ignored");
    tick(); chk(done_o, 0, "R13 no done without stop");
    fifo_cnt_i = 5; stop_req_i = 1; tick(); stop_req_i = 0;
    xfer_end_i = 1; tick(); xfer_end_i = 0;
    start_xfer(1, 0);
    fifo_cnt_i = 0; settle();
    chk(stop_o, 0, "R13 pending discarded at end");
    quiet(); tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    @(negedge clk_i); rst_ni = 1'b1;
    tick();
    t_drain();
    t_xfer_dreq();
    t_stop_sync_send();
    t_stop_sync_recv();
    t_stop_async();
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule